// File: doc/BRIEF.md
# Masked Pin-Change Interrupt Detector

This block watches a group of general-purpose input pins and raises one shared pin-change flag when any enabled pin toggles. Each raw pin first passes through a level-sensitive capture latch and then a clocked synchronizing flop. A change is found by comparing each synchronized value with its value one clock earlier. Rising and falling transitions therefore both count.

A per-pin enable mask selects which pins may contribute. The masked changes are OR-reduced into a single set pulse that sets a sticky group flag. Software clears the flag by writing a one to the clear port. The interrupt request output is the flag gated by a group enable input. Interrupt vectoring, any processor-wide interrupt enable and the pads themselves are outside this block. No data flows through it, so every port is a plain control or status pin with no valid/ready handshake.

Top module: `pin_change_irq`

## Requirements
- R1: When an enabled pin changes level before rising edge k, the flag is still low after edge k and reads high after edge k+1. Edge k is the edge at which the synchronizer captures the new level.
- R2: Rising and falling transitions of an enabled pin both set the flag.
- R3: A level change on pin n while bit n of the mask is 0 leaves the flag unchanged.
- R4: Once set, the flag stays high until a clock edge at which `flag_clr_we_i` is 1 and `flag_clr_data_i` is 1. A write with `flag_clr_data_i` = 0 has no effect.
- R5: When a set pulse and a clearing write fall on the same clock edge, the flag ends high.
- R6: `irq_o` is 1 exactly when the flag is 1 and `irq_en_i` is 1.
- R7: Reset (`rst_n` low, sampled synchronously) clears the mask, the flag and the pin history. `mask_o` shows the mask, and bit n enables pin n. A rising edge with `mask_we_i` high loads `mask_wdata_i`.
- R8: Pins already high when reset is released cause no flag. Detection starts only after two valid samples have been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the capture latch is transparent while it is low |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | 8 | Raw pin levels |
| mask_we_i | input | 1 | Load enable for the per-pin mask |
| mask_wdata_i | input | 8 | New mask value |
| mask_o | output | 8 | Current mask |
| flag_clr_we_i | input | 1 | Write strobe for the flag clear port |
| flag_clr_data_i | input | 1 | Written bit; 1 clears the flag |
| irq_en_i | input | 1 | Group interrupt enable |
| flag_o | output | 1 | Sticky group pin-change flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A pin-change set pulse and a software clear of the flag can land on the same edge. The bench provokes this with the flag already set. It drives a new pin level, and at the next falling edge it asserts a clearing write. That write is sampled on the edge where the set pulse is live. The flag must remain high afterwards, and a second clear with no change pending must lower it. A behavioural reference model compares the flag, the request and the mask against the design on every clock. Random pin, mask and clear traffic exercises the same collision many more times.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int unsigned PCD_PINS_DEF = 8;
  typedef enum logic [1:0] {
    HIST_EMPTY = 2'd0,
    HIST_ONE   = 2'd1,
    HIST_READY = 2'd2
  } hist_state_e;
endpackage

// File: rtl/pcd_pin_front.sv
module pcd_pin_front #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pins_i,
  output logic [PINS-1:0] sync_o,
  output logic            sync_valid_o
);
  logic [PINS-1:0] lat_q;
  logic [PINS-1:0] sync_q;
  logic            valid_q;

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    // transparent while the clock is low, holds across the rising edge
    always_latch begin
      if (!clk) lat_q[g] = pins_i[g];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) sync_q[g] <= 1'b0;
      else        sync_q[g] <= lat_q[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= 1'b1;
  end

  assign sync_o       = sync_q;
  assign sync_valid_o = valid_q;
endmodule

// File: rtl/pcd_change_det.sv
module pcd_change_det #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] sync_i,
  input  logic            sync_valid_i,
  input  logic [PINS-1:0] mask_i,
  output logic            hist_ready_o,
  output logic            set_o
);
  import pcd_pkg::*;

  logic [PINS-1:0] prev_q;
  hist_state_e     hist_q;
  logic [PINS-1:0] toggled;
  logic [PINS-1:0] enabled_hits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      hist_q <= HIST_EMPTY;
    end else begin
      prev_q <= sync_i;
      if (sync_valid_i && hist_q != HIST_READY)
        hist_q <= (hist_q == HIST_EMPTY) ? HIST_ONE : HIST_READY;
    end
  end

  // history holds a real sample once the synchronizer was valid at the last edge
  assign hist_ready_o = (hist_q != HIST_EMPTY);

  for (genvar g = 0; g < PINS; g++) begin : g_cmp
    assign toggled[g]      = sync_i[g] ^ prev_q[g];
    assign enabled_hits[g] = toggled[g] & mask_i[g];
  end

  assign set_o = hist_ready_o & (|enabled_hits);
endmodule

// File: rtl/pcd_mask_reg.sv
module pcd_mask_reg #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [PINS-1:0] wdata_i,
  output logic [PINS-1:0] mask_o
);
  logic [PINS-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    mask_q <= '0;
    else if (we_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/pcd_group_flag.sv
module pcd_group_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_we_i,
  input  logic clr_data_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;
  logic clr_hit;

  assign clr_hit = clr_we_i & clr_data_i;

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_i)   flag_q <= 1'b1;
    else if (clr_hit) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int unsigned PINS = pcd_pkg::PCD_PINS_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pins_i,
  input  logic            mask_we_i,
  input  logic [PINS-1:0] mask_wdata_i,
  output logic [PINS-1:0] mask_o,
  input  logic            flag_clr_we_i,
  input  logic            flag_clr_data_i,
  input  logic            irq_en_i,
  output logic            flag_o,
  output logic            irq_o
);
  logic [PINS-1:0] sync_w;
  logic            sync_valid_w;
  logic [PINS-1:0] mask_w;
  logic            hist_ready_w;
  logic            set_pulse;

  pcd_pin_front #(.PINS(PINS)) u_front (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i),
    .sync_o(sync_w), .sync_valid_o(sync_valid_w)
  );

  pcd_mask_reg #(.PINS(PINS)) u_mask (
    .clk(clk), .rst_n(rst_n), .we_i(mask_we_i),
    .wdata_i(mask_wdata_i), .mask_o(mask_w)
  );

  pcd_change_det #(.PINS(PINS)) u_det (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_w), .sync_valid_i(sync_valid_w),
    .mask_i(mask_w), .hist_ready_o(hist_ready_w), .set_o(set_pulse)
  );

  pcd_group_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(set_pulse),
    .clr_we_i(flag_clr_we_i), .clr_data_i(flag_clr_data_i),
    .en_i(irq_en_i), .flag_o(flag_o), .irq_o(irq_o)
  );

  assign mask_o = mask_w;
endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk (
  input logic clk,
  input logic rst_n,
  input logic set_pulse,
  input logic hist_ready_w,
  input logic flag_clr_we_i,
  input logic flag_clr_data_i,
  input logic irq_en_i,
  input logic flag_o,
  input logic irq_o
);
  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !(flag_clr_we_i && flag_clr_data_i) |=> flag_o);
  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr_we_i && flag_clr_data_i && !set_pulse |=> !flag_o);
  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |=> flag_o);
  // R1
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(set_pulse));
  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_o && irq_en_i));
  // R8
  no_early_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hist_ready_w |-> !set_pulse);
endmodule

bind pin_change_irq pin_change_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .set_pulse(set_pulse), .hist_ready_w(hist_ready_w),
  .flag_clr_we_i(flag_clr_we_i), .flag_clr_data_i(flag_clr_data_i),
  .irq_en_i(irq_en_i), .flag_o(flag_o), .irq_o(irq_o)
);

// File: tb/pin_change_irq_tb_top.sv
`timescale 1ns/1ps
module pin_change_irq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = 8'h00;
  logic       mask_we = 1'b0;
  logic [7:0] mask_wd = 8'h00;
  logic       clr_we = 1'b0;
  logic       clr_d = 1'b0;
  logic       en = 1'b0;
  logic [7:0] mask_o;
  logic       flag_o, irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  pin_change_irq dut_i (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .mask_we_i(mask_we),
    .mask_wdata_i(mask_wd), .mask_o(mask_o), .flag_clr_we_i(clr_we),
    .flag_clr_data_i(clr_d), .irq_en_i(en), .flag_o(flag_o), .irq_o(irq_o)
  );

  // behavioural reference model
  logic [7:0] samples[$];
  logic [7:0] m_mask = 8'h00;
  bit         m_flag = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      samples.delete();
      m_mask = 8'h00;
      m_flag = 1'b0;
    end else begin
      bit hit;
      hit = 1'b0;
      if (samples.size() >= 2)
        hit = |((samples[samples.size()-1] ^ samples[samples.size()-2]) & m_mask);
      m_flag = hit || (m_flag && !(clr_we && clr_d));
      if (mask_we) m_mask = mask_wd;
      samples.push_back(pins);
      if (samples.size() > 4) void'(samples.pop_front());
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(flag_o == m_flag, "R4 model flag", flag_o, m_flag);
      check(irq_o == (m_flag && en), "R6 model irq", irq_o, m_flag && en);
      check(mask_o == m_mask, "R7 model mask", mask_o, m_mask);
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_flag();
    clr_we = 1'b1; clr_d = 1'b1; tick(1); clr_we = 1'b0; clr_d = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    $display("FAIL watchdog expired actual=0 expected=1");
    n_fail++; n_tests++;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    pins = 8'hFF; en = 1'b1;
    tick(3);
    rst_n = 1'b1;
    check(mask_o == 8'h00, "R7 reset mask", mask_o, 0);
    check(flag_o == 1'b0, "R7 reset flag", flag_o, 0);
    // make all pins enabled while they stay high: no spurious change
    mask_we = 1'b1; mask_wd = 8'hFF; tick(1); mask_we = 1'b0;
    tick(4);
    check(flag_o == 1'b0, "R8 no flag after reset", flag_o, 0);
    check(mask_o == 8'hFF, "R7 mask load", mask_o, 8'hFF);

    // R3: only pin 0 enabled, toggle pin 3
    mask_we = 1'b1; mask_wd = 8'h01; tick(1); mask_we = 1'b0;
    tick(2);
    pins = 8'hF7; tick(4);
    check(flag_o == 1'b0, "R3 masked pin ignored", flag_o, 0);

    // R1/R2 falling edge on pin 0 with exact latency
    pins = 8'hF6; tick(1);
    check(flag_o == 1'b0, "R1 not yet after capture edge", flag_o, 0);
    tick(1);
    check(flag_o == 1'b1, "R1 R2 flag after falling edge", flag_o, 1);
    check(irq_o == 1'b1, "R6 irq with enable", irq_o, 1);
    en = 1'b0; tick(1);
    check(irq_o == 1'b0, "R6 irq gated off", irq_o, 0);
    en = 1'b1;

    // R4: write of zero keeps flag, write of one clears
    clr_we = 1'b1; clr_d = 1'b0; tick(1); clr_we = 1'b0;
    check(flag_o == 1'b1, "R4 zero write ignored", flag_o, 1);
    tick(3);
    check(flag_o == 1'b1, "R4 flag sticky", flag_o, 1);
    clear_flag();
    check(flag_o == 1'b0, "R4 one write clears", flag_o, 0);

    // R2 rising edge on pin 0
    pins = 8'hF7; tick(2);
    check(flag_o == 1'b1, "R2 flag after rising edge", flag_o, 1);

    // R5: clear in the cycle where the set pulse is live
    pins = 8'hF6; tick(1);
    clr_we = 1'b1; clr_d = 1'b1; tick(1); clr_we = 1'b0; clr_d = 1'b0;
    check(flag_o == 1'b1, "R5 set wins over clear", flag_o, 1);
    clear_flag();
    check(flag_o == 1'b0, "R5 later clear lowers flag", flag_o, 0);

    // R7: synchronous reset clears state
    pins = 8'hF7; tick(2);
    rst_n = 1'b0; tick(1); rst_n = 1'b1;
    check(flag_o == 1'b0 && mask_o == 8'h00, "R7 reset mid-run", {flag_o, mask_o}, 0);

    // random traffic, compared every cycle against the model
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(3) == 0) pins = 8'($urandom);
      mask_we = ($urandom_range(15) == 0);
      mask_wd = 8'($urandom);
      clr_we  = ($urandom_range(3) == 0);
      clr_d   = 1'($urandom);
      en      = ($urandom_range(7) != 0);
      tick(1);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule